// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Unit

This unit gathers every interrupt cause of a single UART channel and presents them to the host as one prioritized 8-bit status value and one interrupt request line. Receiver, transmitter, line-status, modem-status and flow-control logic signal conditions as single-cycle events, or as a level for the receive-trigger condition. The unit keeps a pending flag for each event-type cause and releases each flag according to that cause's own host access rule.

The host reads the status value to learn which cause to service first. Only the most urgent enabled cause is encoded in bits 5:0. Bits 7:6 report whether the FIFOs are on. Two causes exist only when the enhanced-feature enable is set: an Xoff or special-character match, and a change on the CTS/RTS flow-control pins. The Xoff match also leaves a sticky indication that remains until an Xon character arrives.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, with fifo_en low, `isr` reads 8'h01 and `irq` is low.
- R2: Bits 5:0 carry the code of the highest-priority requesting cause only. The priority order and codes, most urgent first, are: line status 6'b000110, receive time-out 6'b001100, receive data ready 6'b000100, transmit ready 6'b000010, modem status 6'b000000, Xoff/special character 6'b010000, flow-control change 6'b100000.
- R3: Bit 0 is 1 exactly when no cause is requesting. With no request, bits 5:0 are 6'b000001, apart from the sticky bit 4 of R10.
- R4: A cause requests only when its enable bit is set. Enable bits `ien[6:0]` follow the order of R2, with bit 0 for line status and bit 6 for flow-control change. While `enh_en` is low, the Xoff and flow-control causes never request, and bits 5 and 4 read 0.
- R5: A line-status event makes its cause pending from the next cycle. An `lsr_rd` clears the pending flag one cycle later.
- R6: Receive data ready is a level: it requests exactly while `rx_at_trig` is high, in the same cycle.
- R7: A receive time-out event stays pending until an `rhr_rd`.
- R8: Transmit-ready stays pending until an `isr_rd` or a `thr_wr`. For every event-type cause, an event in the same cycle as its clearing access leaves the cause pending.
- R9: Modem-status and flow-control-change pending flags are both cleared by an `msr_rd`.
- R10: An Xoff match sets a pending flag that is cleared by `isr_rd`. It also sets a sticky indication that is cleared only by `xon_rx`. While `enh_en` is high, the sticky indication forces bit 4 to 1 whatever the code.
- R11: Bits 7:6 read 2'b11 while `fifo_en` is high and 2'b00 while it is low.
- R12: `irq` is high in a cycle exactly when bit 0 of `isr` was 0 in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | FIFOs enabled |
| enh_en | input | 1 | Enhanced-feature enable |
| ien | input | 7 | Per-cause enables, priority order |
| lsr_evt | input | 1 | Line error event |
| rx_tmo_evt | input | 1 | Receive time-out event |
| rx_at_trig | input | 1 | Receive FIFO at or above trigger level |
| tx_rdy_evt | input | 1 | Transmit-ready event |
| msr_evt | input | 1 | Modem status change event |
| xoff_rx | input | 1 | Xoff/special character matched |
| xon_rx | input | 1 | Xon character received |
| flow_evt | input | 1 | CTS/RTS change event |
| isr_rd | input | 1 | Host read of status value |
| lsr_rd | input | 1 | Host read of line status |
| msr_rd | input | 1 | Host read of modem status |
| rhr_rd | input | 1 | Host read of receive holding register |
| thr_wr | input | 1 | Host write of transmit holding register |
| isr | output | 8 | Interrupt status value |
| irq | output | 1 | Registered interrupt request |

## Verification
Directed sequences first raise one cause at a time and then stack several causes, removing them in order with their clearing accesses. This separates a wrong code or a wrong priority from a wrong clear rule. Event and clear in the same cycle is driven for each latched cause, to tell a set-wins flag from a clear-wins one. Toggling `enh_en` and the enables around a pending Xoff shows masking apart from loss of state. A long random stretch then mixes every event, strobe and enable against a bench model, which catches cross-effects between clear rules that the directed cases do not reach.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   localparam int NUM_LVL  = 7;
   localparam int CODE_W   = 6;
   localparam int STAT_W   = 8;

   localparam int LVL_LINE = 0;
   localparam int LVL_TMO  = 1;
   localparam int LVL_RXD  = 2;
   localparam int LVL_TX   = 3;
   localparam int LVL_MDM  = 4;
   localparam int LVL_XOFF = 5;
   localparam int LVL_FLOW = 6;

   localparam logic [CODE_W-1:0] CODE_NONE = 6'b000001;

   function automatic logic [CODE_W-1:0] lvl_code(input int lvl);
      case (lvl)
         LVL_LINE: lvl_code = 6'b000110;
         LVL_TMO:  lvl_code = 6'b001100;
         LVL_RXD:  lvl_code = 6'b000100;
         LVL_TX:   lvl_code = 6'b000010;
         LVL_MDM:  lvl_code = 6'b000000;
         LVL_XOFF: lvl_code = 6'b010000;
         LVL_FLOW: lvl_code = 6'b100000;
         default:  lvl_code = CODE_NONE;
      endcase
   endfunction
endpackage

// File: rtl/uart_irq_flag.sv
module uart_irq_flag #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   logic q_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_q <= 1'b0;
      end else begin
         if (SET_WINS) begin
            if (set_i)      q_q <= 1'b1;
            else if (clr_i) q_q <= 1'b0;
         end else begin
            if (clr_i)      q_q <= 1'b0;
            else if (set_i) q_q <= 1'b1;
         end
      end
   end

   assign q_o = q_q;

   generate
      if (SET_WINS) begin : g_setwin_chk
         assert_set_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
            set_i |=> q_o);
         assert_clear_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && !set_i) |=> !q_o);
      end else begin : g_clrwin_chk
         assert_clear_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
            clr_i |=> !q_o);
      end
   endgenerate

   assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
   import uart_irq_pkg::*;
#(
   parameter int LVLS = NUM_LVL
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LVLS-1:0]   req_i,
   output logic [CODE_W-1:0] code_o
);
   generate
      if (LVLS != NUM_LVL) begin : g_bad_lvls
         $error("uart_irq_prio: LVLS must equal the defined level count");
      end
   endgenerate

   always_comb begin
      code_o = CODE_NONE;
      for (int i = LVLS - 1; i >= 0; i--) begin
         if (req_i[i]) code_o = lvl_code(i);
      end
   end

   assert_none_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i == '0) |-> (code_o == CODE_NONE));
   assert_top_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_i[LVL_LINE] |-> (code_o == 6'b000110));
   assert_pending_bit0_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i != '0) |-> !code_o[0]);
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
   import uart_irq_pkg::*;
#(
   parameter int STATUS_W = STAT_W,
   parameter bit IRQ_REG  = 1'b1,
   parameter bit SET_WINS = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fifo_en,
   input  logic               enh_en,
   input  logic [NUM_LVL-1:0] ien,
   input  logic               lsr_evt,
   input  logic               rx_tmo_evt,
   input  logic               rx_at_trig,
   input  logic               tx_rdy_evt,
   input  logic               msr_evt,
   input  logic               xoff_rx,
   input  logic               xon_rx,
   input  logic               flow_evt,
   input  logic               isr_rd,
   input  logic               lsr_rd,
   input  logic               msr_rd,
   input  logic               rhr_rd,
   input  logic               thr_wr,
   output logic [STATUS_W-1:0] isr,
   output logic               irq
);
   localparam int NFLAG = 7;
   localparam int F_LINE = 0, F_TMO = 1, F_TX = 2, F_MDM = 3,
                  F_XOFF = 4, F_FLOW = 5, F_STICKY = 6;

   generate
      if (STATUS_W != STAT_W) begin : g_bad_w
         $error("uart_irq_ident: STATUS_W must be 8");
      end
   endgenerate

   logic [NFLAG-1:0] set_v, clr_v, flag_q;

   always_comb begin
      set_v = '0;
      clr_v = '0;
      set_v[F_LINE]   = lsr_evt;     clr_v[F_LINE]   = lsr_rd;
      set_v[F_TMO]    = rx_tmo_evt;  clr_v[F_TMO]    = rhr_rd;
      set_v[F_TX]     = tx_rdy_evt;  clr_v[F_TX]     = isr_rd | thr_wr;
      set_v[F_MDM]    = msr_evt;     clr_v[F_MDM]    = msr_rd;
      set_v[F_XOFF]   = xoff_rx;     clr_v[F_XOFF]   = isr_rd;
      set_v[F_FLOW]   = flow_evt;    clr_v[F_FLOW]   = msr_rd;
      set_v[F_STICKY] = xoff_rx;     clr_v[F_STICKY] = xon_rx;
   end

   genvar g;
   generate
      for (g = 0; g < NFLAG; g++) begin : g_flag
         uart_irq_flag #(.SET_WINS(SET_WINS)) u_flag (
            .clk  (clk),
            .rst_n(rst_n),
            .set_i(set_v[g]),
            .clr_i(clr_v[g]),
            .q_o  (flag_q[g])
         );
      end
   endgenerate

   logic [NUM_LVL-1:0] raw_req, req;

   always_comb begin
      raw_req           = '0;
      raw_req[LVL_LINE] = flag_q[F_LINE];
      raw_req[LVL_TMO]  = flag_q[F_TMO];
      raw_req[LVL_RXD]  = rx_at_trig;
      raw_req[LVL_TX]   = flag_q[F_TX];
      raw_req[LVL_MDM]  = flag_q[F_MDM];
      raw_req[LVL_XOFF] = flag_q[F_XOFF] & enh_en;
      raw_req[LVL_FLOW] = flag_q[F_FLOW] & enh_en;
      req               = raw_req & ien;
   end

   logic [CODE_W-1:0] code;

   uart_irq_prio #(.LVLS(NUM_LVL)) u_prio (
      .clk   (clk),
      .rst_n (rst_n),
      .req_i (req),
      .code_o(code)
   );

   logic sticky_vis;
   assign sticky_vis = enh_en & flag_q[F_STICKY];

   always_comb begin
      isr       = {{2{fifo_en}}, code};
      isr[4]    = code[4] | sticky_vis;
   end

   logic pend;
   assign pend = !code[0];

   generate
      if (IRQ_REG) begin : g_irq_ff
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= pend;
         end
         assign irq = irq_q;

         assert_irq_follow_R12: assert property (@(posedge clk) disable iff (!rst_n)
            !isr[0] |=> irq);
         assert_irq_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
            isr[0] |=> !irq);
      end else begin : g_irq_comb
         assign irq = pend;
      end
   endgenerate

   assert_enh_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !enh_en |-> (isr[5:4] == 2'b00));
   assert_fifo_bits_R11: assert property (@(posedge clk) disable iff (!rst_n)
      isr[7:6] == {fifo_en, fifo_en});
   assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (xoff_rx && !xon_rx) |=> (!enh_en || isr[4]));
   assert_rxd_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_at_trig && ien[LVL_RXD] && !req[LVL_LINE] && !req[LVL_TMO])
         |-> (isr[3:0] == 4'b0100));
endmodule

// File: tb/tb_uart_irq_ident.sv
module tb_uart_irq_ident;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fifo_en = 0, enh_en = 0;
   logic [6:0] ien = '0;
   logic lsr_evt = 0, rx_tmo_evt = 0, rx_at_trig = 0, tx_rdy_evt = 0, msr_evt = 0;
   logic xoff_rx = 0, xon_rx = 0, flow_evt = 0;
   logic isr_rd = 0, lsr_rd = 0, msr_rd = 0, rhr_rd = 0, thr_wr = 0;
   logic [7:0] isr;
   logic irq;

   int n_chk = 0, n_err = 0;

   // bench model state
   logic m_line = 0, m_tmo = 0, m_tx = 0, m_mdm = 0, m_xoff = 0, m_flow = 0, m_stk = 0;
   logic m_irq = 0;

   always #4 clk = ~clk;

   uart_irq_ident dut (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .enh_en(enh_en), .ien(ien),
      .lsr_evt(lsr_evt), .rx_tmo_evt(rx_tmo_evt), .rx_at_trig(rx_at_trig),
      .tx_rdy_evt(tx_rdy_evt), .msr_evt(msr_evt), .xoff_rx(xoff_rx), .xon_rx(xon_rx),
      .flow_evt(flow_evt), .isr_rd(isr_rd), .lsr_rd(lsr_rd), .msr_rd(msr_rd),
      .rhr_rd(rhr_rd), .thr_wr(thr_wr), .isr(isr), .irq(irq)
   );

   function automatic logic [7:0] exp_isr();
      logic [6:0] r;
      logic [5:0] c;
      r[0] = m_line; r[1] = m_tmo; r[2] = rx_at_trig; r[3] = m_tx;
      r[4] = m_mdm;  r[5] = m_xoff & enh_en; r[6] = m_flow & enh_en;
      r = r & ien;
      if      (r[0]) c = 6'b000110;
      else if (r[1]) c = 6'b001100;
      else if (r[2]) c = 6'b000100;
      else if (r[3]) c = 6'b000010;
      else if (r[4]) c = 6'b000000;
      else if (r[5]) c = 6'b010000;
      else if (r[6]) c = 6'b100000;
      else           c = 6'b000001;
      c[4] = c[4] | (enh_en & m_stk);
      return {{2{fifo_en}}, c};
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   // inputs already driven after a negedge: check, update model, advance
   task automatic step(input string req);
      #1;
      chk(req, isr, exp_isr());
      chk({req, "/R12 irq"}, {7'd0, irq}, {7'd0, m_irq});
      m_irq = !exp_isr()[0];
      if (lsr_evt) m_line = 1; else if (lsr_rd) m_line = 0;
      if (rx_tmo_evt) m_tmo = 1; else if (rhr_rd) m_tmo = 0;
      if (tx_rdy_evt) m_tx = 1; else if (isr_rd || thr_wr) m_tx = 0;
      if (msr_evt) m_mdm = 1; else if (msr_rd) m_mdm = 0;
      if (xoff_rx) m_xoff = 1; else if (isr_rd) m_xoff = 0;
      if (flow_evt) m_flow = 1; else if (msr_rd) m_flow = 0;
      if (xoff_rx) m_stk = 1; else if (xon_rx) m_stk = 0;
      @(negedge clk);
      {lsr_evt, rx_tmo_evt, tx_rdy_evt, msr_evt, xoff_rx, xon_rx, flow_evt} = '0;
      {isr_rd, lsr_rd, msr_rd, rhr_rd, thr_wr} = '0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd1759));
      #2;
      chk("R1 reset isr", isr, 8'h01);
      chk("R1 reset irq", {7'd0, irq}, 8'h00);
      @(negedge clk); @(negedge clk);
      rst_n = 1;
      ien = 7'h7f;
      step("R1 idle");
      // R5 line status, and priority over lower sources (R2)
      lsr_evt = 1; tx_rdy_evt = 1; step("R5 set");
      step("R2 line over tx");
      lsr_rd = 1; step("R5 clear");
      step("R8 tx exposed");
      thr_wr = 1; step("R8 thr clears");
      step("R3 none");
      // R8 set and clear together keeps pending
      tx_rdy_evt = 1; step("R8 set");
      tx_rdy_evt = 1; isr_rd = 1; step("R8 same cycle");
      step("R8 still pending");
      isr_rd = 1; step("R8 isr_rd clears");
      // R6 level, R7 time-out
      rx_at_trig = 1; step("R6 level on");
      rx_tmo_evt = 1; step("R7 set");
      step("R7 over rxd");
      rhr_rd = 1; step("R7 rhr clears");
      rx_at_trig = 0; step("R6 level off");
      // R9 modem and flow change, R4 enh masking
      msr_evt = 1; flow_evt = 1; step("R9 set");
      step("R9 msr shown");
      enh_en = 1; step("R4 enh on");
      msr_rd = 1; step("R9 msr_rd clears both");
      // R10 xoff pending and sticky
      xoff_rx = 1; step("R10 set");
      step("R10 code");
      isr_rd = 1; step("R10 isr read");
      step("R10 sticky stays");
      lsr_evt = 1; step("R10 sticky with line");
      lsr_rd = 1; step("R10 line gone");
      enh_en = 0; step("R4 sticky masked");
      enh_en = 1; xon_rx = 1; step("R10 xon");
      step("R10 sticky off");
      // R4 per-cause enable, R11 fifo bits
      ien = 7'b1111110; lsr_evt = 1; step("R4 masked line");
      step("R4 masked line hidden");
      fifo_en = 1; step("R11 fifo on");
      ien = 7'h7f; step("R4 unmasked line");
      lsr_rd = 1; step("R5 clear again");
      fifo_en = 0; step("R11 fifo off");
      // random stretch
      for (int i = 0; i < 3000; i++) begin
         lsr_evt    = ($urandom % 10) == 0;
         rx_tmo_evt = ($urandom % 10) == 0;
         tx_rdy_evt = ($urandom % 8) == 0;
         msr_evt    = ($urandom % 10) == 0;
         xoff_rx    = ($urandom % 12) == 0;
         xon_rx     = ($urandom % 12) == 0;
         flow_evt   = ($urandom % 10) == 0;
         isr_rd     = ($urandom % 6) == 0;
         lsr_rd     = ($urandom % 6) == 0;
         msr_rd     = ($urandom % 6) == 0;
         rhr_rd     = ($urandom % 6) == 0;
         thr_wr     = ($urandom % 7) == 0;
         if (($urandom % 5) == 0) rx_at_trig = $urandom;
         if (($urandom % 40) == 0) enh_en = $urandom;
         if (($urandom % 40) == 0) fifo_en = $urandom;
         if (($urandom % 30) == 0) ien = $urandom;
         step("R2 random");
      end
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule